// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is a device-side model of the status word a NOR flash returns while an embedded program or erase runs. It keeps the operation's mode (idle, running, suspended, failed), the set of sectors chosen for erase, and a count of internal pulses. On every read cycle it returns either array data or a status word. The status word carries two toggle bits and one error flag.

The two toggle bits have different meanings. The mode toggle inverts on each read while the operation is running and freezes during suspend. The sector toggle inverts only when the read address falls inside a sector marked for erase, and it does so whether the erase is running or suspended. Host software reads both bits to tell active erase from erase-suspend, and to learn which sectors are selected.

The error flag rises when the pulse count passes a configurable limit. It also rises when a program tries to raise a programmed bit. A reset command returns the block to array reads. Array storage, command decoding and real erase timing are replaced here by simple control inputs.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `busy` is 0 and `dout` is all zeros.
- R2: When the block is idle, a read returns `array_data`. A read in the same cycle as the `op_start` that launches an operation also returns `array_data`. Status appears only from the cycle after that `op_start`.
- R3: A pulse on either `oe_rd` or `ce_rd` is one read cycle, and both in the same cycle count as a single read. The read result appears on `dout` one clock later and holds until the next read.
- R4: The status word places the mode toggle at bit 6, the error flag at bit 5 and the sector toggle at bit 2. All other bits are 0.
- R5: The first status read after an operation starts shows both toggles as 0. While the operation is running or failed, the mode toggle (bit 6) inverts after every read.
- R6: During erase-suspend the mode toggle holds its value across reads.
- R7: The sector toggle (bit 2) inverts only on reads whose sector lies in the erase selection. The sector is the upper `SEC_BITS` bits of `rd_addr`. This holds in the running, suspended and failed modes. A program operation has no selected sectors.
- R8: `suspend_req` takes effect only during a running erase and is ignored during a program. While suspended, a read of an unselected sector returns `array_data`. `resume_req` returns the block to running.
- R9: `pulse_tick` is counted only while running. When the count would exceed `pulse_limit`, the block enters the failed mode. In the failed mode bit 5 is 1 and both toggles keep toggling.
- R10: During a program operation, `prog_clash` enters the failed mode. During an erase it has no effect.
- R11: `op_done` while running returns the block to idle. It wins over a limit overflow in the same cycle.
- R12: `reset_cmd` moves the failed mode to idle and clears the error flag. It is ignored while running or suspended. `op_start` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Final write strobe of a program/erase command |
| op_is_erase | input | 1 | 1 selects erase, 0 selects program |
| erase_mask | input | 2**SEC_BITS | Sectors chosen for erase, captured at start |
| suspend_req | input | 1 | Erase-suspend command |
| resume_req | input | 1 | Erase-resume command |
| op_done | input | 1 | Operation finished successfully |
| pulse_tick | input | 1 | One internal program/erase pulse |
| pulse_limit | input | PULSE_W | Largest allowed pulse count |
| prog_clash | input | 1 | Program attempted to raise a 0 bit to 1 |
| reset_cmd | input | 1 | Reset command |
| oe_rd | input | 1 | Read cycle timed by output enable |
| ce_rd | input | 1 | Read cycle timed by chip enable |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Array contents at the read address |
| dout | output | DATA_W | Registered read result |
| busy | output | 1 | An operation is in progress, suspended or failed |

## Verification
The bound checker tests several rules on every cycle: the mode toggle freezes in suspend and flips on every running read, the sector toggle stays put outside selected reads, `dout` holds between reads, and the failed mode always carries the error flag and leaves on reset. Other behaviours only the directed scenarios can show. These are the exact status words returned by read sequences across selected and unselected sectors, and the return of array data during suspend. They also cover the pulse-limit boundary (limit passes, limit plus one fails), priority between `op_done` and overflow, and the commands that must be ignored.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_SUSP = 2'd2,
        MODE_FAIL = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  is_erase;
        logic  err;
    } ctrl_s;

    typedef struct packed {
        logic t6;
        logic t2;
    } tog_s;

    localparam int unsigned BIT_MODE_TOG = 6;
    localparam int unsigned BIT_ERR      = 5;
    localparam int unsigned BIT_SECT_TOG = 2;

endpackage

// File: rtl/fsg_sector_decode.sv
module fsg_sector_decode #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned SEC_BITS = 4,
    localparam int unsigned NSEC    = 1 << SEC_BITS,
    localparam int unsigned SEC_LSB = ADDR_W - SEC_BITS
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSEC-1:0]   sel_mask,
    output logic              hit
);
    logic [SEC_BITS-1:0] idx;
    logic [NSEC-1:0]     match;

    assign idx = rd_addr[ADDR_W-1:SEC_LSB];

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        assign match[g] = sel_mask[g] && (idx == SEC_BITS'(g));
    end

    assign hit = |match;
endmodule

// File: rtl/fsg_pulse_counter.sv
module fsg_pulse_counter #(
    parameter int unsigned PULSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               tick_en,
    input  logic [PULSE_W-1:0] limit,
    output logic               over
);
    logic [PULSE_W-1:0] cnt_d, cnt_q;
    logic [PULSE_W:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt_q} + {{PULSE_W{1'b0}}, 1'b1};
    assign over   = tick_en && (cnt_nx > {1'b0, limit});

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick_en && (cnt_q != '1)) begin
            cnt_d = cnt_nx[PULSE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import flash_status_pkg::*;
#(
    parameter int unsigned NSEC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_start,
    input  logic            op_is_erase,
    input  logic [NSEC-1:0] erase_mask,
    input  logic            suspend_req,
    input  logic            resume_req,
    input  logic            op_done,
    input  logic            over,
    input  logic            prog_clash,
    input  logic            reset_cmd,
    output mode_e           mode,
    output logic            err,
    output logic            start_ok,
    output logic [NSEC-1:0] sel_mask
);
    ctrl_s           st_d, st_q;
    logic [NSEC-1:0] mask_d, mask_q;

    always_comb begin
        st_d     = st_q;
        mask_d   = mask_q;
        start_ok = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (op_start) begin
                    st_d.mode     = MODE_RUN;
                    st_d.is_erase = op_is_erase;
                    st_d.err      = 1'b0;
                    mask_d        = op_is_erase ? erase_mask : '0;
                    start_ok      = 1'b1;
                end
            end
            MODE_RUN: begin
                if (op_done) begin
                    st_d.mode = MODE_IDLE;
                    mask_d    = '0;
                end else if (over || (prog_clash && !st_q.is_erase)) begin
                    st_d.mode = MODE_FAIL;
                    st_d.err  = 1'b1;
                end else if (suspend_req && st_q.is_erase) begin
                    st_d.mode = MODE_SUSP;
                end
            end
            MODE_SUSP: begin
                if (resume_req) st_d.mode = MODE_RUN;
            end
            MODE_FAIL: begin
                if (reset_cmd) begin
                    st_d.mode = MODE_IDLE;
                    st_d.err  = 1'b0;
                    mask_d    = '0;
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '{mode: MODE_IDLE, is_erase: 1'b0, err: 1'b0};
            mask_q <= '0;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
        end
    end

    assign mode     = st_q.mode;
    assign err      = st_q.err;
    assign sel_mask = mask_q;
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
    import flash_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  rd,
    input  mode_e mode,
    input  logic  hit,
    output logic  t6,
    output logic  t2
);
    tog_s tg_d, tg_q;
    logic running, live;

    assign running = (mode == MODE_RUN) || (mode == MODE_FAIL);
    assign live    = running || (mode == MODE_SUSP);

    always_comb begin
        tg_d = tg_q;
        if (clear) begin
            tg_d = '0;
        end else if (rd) begin
            if (running)     tg_d.t6 = ~tg_q.t6;
            if (live && hit) tg_d.t2 = ~tg_q.t2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign t6 = tg_q.t6;
    assign t2 = tg_q.t2;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned SEC_BITS = 4,
    parameter int unsigned PULSE_W  = 8,
    parameter int unsigned DATA_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_start,
    input  logic                      op_is_erase,
    input  logic [(1<<SEC_BITS)-1:0]  erase_mask,
    input  logic                      suspend_req,
    input  logic                      resume_req,
    input  logic                      op_done,
    input  logic                      pulse_tick,
    input  logic [PULSE_W-1:0]        pulse_limit,
    input  logic                      prog_clash,
    input  logic                      reset_cmd,
    input  logic                      oe_rd,
    input  logic                      ce_rd,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [DATA_W-1:0]         array_data,
    output logic [DATA_W-1:0]         dout,
    output logic                      busy
);
    localparam int unsigned NSEC = 1 << SEC_BITS;

    mode_e             mode_w;
    logic              err_w, start_ok, over, sec_hit, rd, t6_w, t2_w, show;
    logic [NSEC-1:0]   sel_mask;
    logic [DATA_W-1:0] status, dout_d, dout_q;

    assign rd = oe_rd | ce_rd;

    fsg_sector_decode #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS)) u_dec (
        .rd_addr (rd_addr),
        .sel_mask(sel_mask),
        .hit     (sec_hit)
    );

    fsg_pulse_counter #(.PULSE_W(PULSE_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_ok),
        .tick_en(pulse_tick && (mode_w == MODE_RUN)),
        .limit  (pulse_limit),
        .over   (over)
    );

    fsg_ctrl #(.NSEC(NSEC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_is_erase(op_is_erase),
        .erase_mask (erase_mask),
        .suspend_req(suspend_req),
        .resume_req (resume_req),
        .op_done    (op_done),
        .over       (over),
        .prog_clash (prog_clash),
        .reset_cmd  (reset_cmd),
        .mode       (mode_w),
        .err        (err_w),
        .start_ok   (start_ok),
        .sel_mask   (sel_mask)
    );

    fsg_toggle u_tog (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(start_ok),
        .rd   (rd),
        .mode (mode_w),
        .hit  (sec_hit),
        .t6   (t6_w),
        .t2   (t2_w)
    );

    assign show = (mode_w == MODE_RUN) || (mode_w == MODE_FAIL) ||
                  ((mode_w == MODE_SUSP) && sec_hit);

    always_comb begin
        status               = '0;
        status[BIT_MODE_TOG] = t6_w;
        status[BIT_ERR]      = err_w;
        status[BIT_SECT_TOG] = t2_w;
        dout_d = dout_q;
        if (rd) dout_d = show ? status : array_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign dout = dout_q;
    assign busy = (mode_w != MODE_IDLE);
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
    import flash_status_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input mode_e             mode,
    input logic              err,
    input logic              t6,
    input logic              t2,
    input logic              rd,
    input logic              hit,
    input logic              reset_cmd,
    input logic [DATA_W-1:0] dout
);
    // R6: mode toggle frozen in suspend
    a_r6_dq6_hold_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUSP) |=> (t6 == $past(t6)));

    // R5: mode toggle inverts on every running read
    a_r5_dq6_flip_run: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && mode == MODE_RUN) |=> (t6 != $past(t6)));

    // R7: sector toggle steady without a selected read
    a_r7_dq2_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_IDLE && !(rd && hit)) |=> $stable(t2));

    // R3: output holds between reads
    a_r3_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(dout));

    // R9: failed mode always carries the error flag
    a_r9_fail_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIL) |-> err);

    // R12: reset command leaves failure and clears the flag
    a_r12_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIL && reset_cmd) |=> (mode == MODE_IDLE && !err));
endmodule

bind flash_status_gen fsg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_w),
    .err      (err_w),
    .t6       (t6_w),
    .t2       (t2_w),
    .rd       (rd),
    .hit      (sec_hit),
    .reset_cmd(reset_cmd),
    .dout     (dout)
);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 0, op_is_erase = 0, suspend_req = 0, resume_req = 0;
    logic        op_done = 0, pulse_tick = 0, prog_clash = 0, reset_cmd = 0;
    logic        oe_rd = 0, ce_rd = 0;
    logic [15:0] erase_mask = '0;
    logic [7:0]  pulse_limit = 8'd3;
    logic [11:0] rd_addr = '0;
    logic [7:0]  array_data = 8'h3C;
    logic [7:0]  dout;
    logic        busy;
    int          n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    flash_status_gen dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .erase_mask(erase_mask), .suspend_req(suspend_req), .resume_req(resume_req),
        .op_done(op_done), .pulse_tick(pulse_tick), .pulse_limit(pulse_limit),
        .prog_clash(prog_clash), .reset_cmd(reset_cmd), .oe_rd(oe_rd), .ce_rd(ce_rd),
        .rd_addr(rd_addr), .array_data(array_data), .dout(dout), .busy(busy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr();
        op_start = 0; suspend_req = 0; resume_req = 0; op_done = 0;
        pulse_tick = 0; prog_clash = 0; reset_cmd = 0; oe_rd = 0; ce_rd = 0;
    endtask

    // one read cycle; dout is sampled on the following falling edge
    task automatic rd(input logic [11:0] a, input bit oe, input bit ce,
                      input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a; oe_rd = oe; ce_rd = ce;
        @(negedge clk);
        clr();
        chk(tag, dout, exp);
    endtask

    task automatic start(input bit er, input logic [15:0] m);
        @(negedge clk); op_start = 1; op_is_erase = er; erase_mask = m;
        @(negedge clk); clr();
    endtask

    task automatic t_reset();
        chk("R1 dout", dout, 8'h00);
        chk("R1 busy", {7'd0, busy}, 8'h01 & 8'h00);
        rd(12'h000, 1, 0, 8'h3C, "R2 idle read");
    endtask

    task automatic t_erase_susp();
        // read issued together with the launching write strobe sees array data
        @(negedge clk);
        op_start = 1; op_is_erase = 1; erase_mask = 16'h0003;
        oe_rd = 1; rd_addr = 12'h010;
        @(negedge clk); clr();
        chk("R2 read at start", dout, 8'h3C);
        chk("R12 busy after start", {7'd0, busy}, 8'h01);
        rd(12'h010, 1, 0, 8'h00, "R5 first status");
        rd(12'h1FF, 1, 0, 8'h44, "R4 R7 selected sector");
        rd(12'h500, 1, 0, 8'h00, "R7 unselected no dq2 flip");
        rd(12'h2AA, 1, 0, 8'h40, "R5 dq6 flips");
        rd(12'h000, 0, 1, 8'h00, "R3 chip-enable read");
        rd(12'h000, 1, 0, 8'h44, "R3 output-enable read");
        @(negedge clk); suspend_req = 1; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h00, "R6 suspend read1");
        rd(12'h100, 1, 0, 8'h04, "R6 R7 suspend dq2 toggles");
        rd(12'h000, 1, 0, 8'h00, "R6 suspend dq6 held");
        rd(12'h500, 1, 0, 8'h3C, "R8 suspend unselected array");
        repeat (3) @(negedge clk);
        chk("R3 hold", dout, 8'h3C);
        @(negedge clk); reset_cmd = 1; op_done = 1; @(negedge clk); clr();
        chk("R12 reset ignored in suspend", {7'd0, busy}, 8'h01);
        @(negedge clk); resume_req = 1; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h04, "R8 resume running");
        @(negedge clk); op_done = 1; @(negedge clk); clr();
        chk("R11 done idle", {7'd0, busy}, 8'h00);
        rd(12'h000, 1, 0, 8'h3C, "R11 idle array read");
    endtask

    task automatic t_program_clash();
        start(0, 16'hFFFF);
        rd(12'h000, 1, 1, 8'h00, "R3 both strobes one read");
        rd(12'h000, 1, 0, 8'h40, "R7 program no dq2");
        @(negedge clk); suspend_req = 1; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h00, "R8 suspend ignored in program");
        @(negedge clk); prog_clash = 1; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h60, "R10 clash fails");
        rd(12'h000, 1, 0, 8'h20, "R9 toggles continue in fail");
        @(negedge clk); reset_cmd = 1; @(negedge clk); clr();
        chk("R12 reset leaves fail", {7'd0, busy}, 8'h00);
        rd(12'h000, 1, 0, 8'h3C, "R12 array after reset");
    endtask

    task automatic t_limit();
        pulse_limit = 8'd3;
        start(1, 16'h0001);
        @(negedge clk); prog_clash = 1; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h00, "R10 clash ignored in erase");
        @(negedge clk); op_start = 1; op_is_erase = 0; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h44, "R12 start ignored while busy");
        @(negedge clk); reset_cmd = 1; @(negedge clk); clr();
        chk("R12 reset ignored running", {7'd0, busy}, 8'h01);
        repeat (3) begin
            @(negedge clk); pulse_tick = 1; @(negedge clk); clr();
        end
        rd(12'h000, 1, 0, 8'h00, "R9 at limit no error");
        @(negedge clk); pulse_tick = 1; @(negedge clk); clr();
        rd(12'h000, 1, 0, 8'h64, "R9 over limit fails");
        @(negedge clk); reset_cmd = 1; @(negedge clk); clr();
        // done beats overflow; counter restarts with each operation
        start(1, 16'h0001);
        repeat (3) begin
            @(negedge clk); pulse_tick = 1; @(negedge clk); clr();
        end
        @(negedge clk); pulse_tick = 1; op_done = 1; @(negedge clk); clr();
        chk("R11 done wins", {7'd0, busy}, 8'h00);
        rd(12'h000, 1, 0, 8'h3C, "R11 no failure");
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erase_susp();
        t_program_clash();
        t_limit();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule